// File: doc/BRIEF.md
# Recirculating Longest-Prefix Route Lookup Engine

This block turns a 32-bit IPv4 destination address into a 31-bit routing result by walking a three-level sparse table. The table sits in one external synchronous RAM that needs several cycles per read. The upper 16 address bits index the first level directly. A pointer entry sends the lookup on to a 256-entry block, which is indexed by the next address byte. Each lookup stops at the first leaf it meets, so it makes one, two or three reads.

All lookups share one RAM port through a feedback loop. A small queue keeps each in-flight lookup's unused address bits, its depth and its ordering token while its read is outstanding. RAM responses come back in request order, so the head of that queue always belongs to the response at the port. A non-leaf response is sent straight back to the RAM. A leaf response is written into a reorder buffer, which releases results strictly in the order the requests were accepted.

Both streams use valid/ready and transfer on a cycle where both are high. The requester must hold `req_valid` and `req_addr` steady until `req_ready`. The block holds `rsp_valid` and `rsp_result` steady until `rsp_ready`. The RAM side uses the same rules. The RAM returns responses in the order it accepted reads, and it keeps a response valid until `mem_rsp_ready`.

Top module: `lpm_engine`

## Requirements
- R1: When a request is accepted, in that same cycle the block issues a RAM read whose address is `req_addr[31:16]`, zero-extended.
- R2: A non-leaf entry (bit 31 = 0) found at depth 1 causes a read at `entry[AW-1:0] + req_addr[15:8]`. One found at depth 2 causes a read at `entry[AW-1:0] + req_addr[7:0]`.
- R3: An entry with bit 31 = 1 ends the lookup with result `entry[30:0]`. A depth-3 entry always ends the lookup and yields `entry[30:0]` whatever its bit 31.
- R4: While a response that needs a follow-up read is waiting at the RAM port, `req_ready` stays low. Recirculation has priority over new entries.
- R5: A finishing lookup does not use the RAM, so a new request can be admitted in the same cycle. With both ready inputs held high and leaf-only traffic, one request is accepted every cycle.
- R6: Results leave in the order their requests were accepted, even when they finish out of order.
- R7: A request is admitted only if a token is free, the recirculation queue has room (counting a pop in the same cycle) and the RAM accepts the read. No more than NTOK lookups are ever in flight.
- R8: Once `rsp_valid` is high, it and `rsp_result` stay unchanged until `rsp_ready` is sampled high.
- R9: After reset, `rsp_valid`, `mem_req_valid` and `req_ready` are low while no request is offered.
- R10: A RAM response is consumed in the cycle it ends a lookup, or in the cycle its follow-up read is accepted, and in no other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | 32 | Destination address to resolve |
| rsp_valid | output | 1 | Result offered |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_result | output | 31 | Leaf value of the finished lookup |
| mem_req_valid | output | 1 | RAM read request |
| mem_req_ready | input | 1 | RAM accepts the read |
| mem_req_addr | output | AW | RAM word address |
| mem_rsp_valid | input | 1 | RAM read data available |
| mem_rsp_ready | output | 1 | Block consumes the read data |
| mem_rsp_data | input | 32 | Table entry: bit 31 leaf flag, bits 30:0 value or pointer |

## Verification
The bench builds the engine with AW = 20, a recirculation queue depth of 4 and NTOK = 8. Its RAM model has a fixed read latency of 4, which equals the queue depth. A back-to-back leaf stream therefore keeps the queue full, and each cycle it needs a push while the queue is full and a pop is happening. Eight tokens is small enough that holding the result stream off reaches the in-flight limit within a few cycles. The table places pointer entries at every fourth second-level byte, plus one non-leaf entry at the third level, so random addresses hit one-, two- and three-read lookups. Random RAM and consumer stalls then make later lookups finish ahead of earlier ones.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int ENTRY_W  = 32;
  localparam int LEAF_BIT = 31;
  localparam int RES_W    = 31;
  localparam int REM_W    = 16;
  localparam int LVL_W    = 2;
  localparam logic [LVL_W-1:0] LVL_FIRST = 2'd0;
  localparam logic [LVL_W-1:0] LVL_LAST  = 2'd2;
endpackage

// File: rtl/lpm_loop_fifo.sv
module lpm_loop_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         space
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  // a pop in this cycle frees a slot for a push in the same cycle
  assign space = !full || pop;
  assign dout  = store[rp];

  always_ff @(posedge clk) begin
    if (push) store[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/lpm_cbuf.sv
module lpm_cbuf #(
  parameter int NTOK  = 8,
  parameter int RW    = 31,
  localparam int TW   = (NTOK > 1) ? $clog2(NTOK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  output logic          tok_ok,
  output logic [TW-1:0] alloc_tok,
  input  logic          put,
  input  logic [TW-1:0] put_tok,
  input  logic [RW-1:0] put_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [RW-1:0] out_data
);
  localparam int CW = $clog2(NTOK + 1);

  logic [NTOK-1:0] filled;
  logic [RW-1:0]   slot [NTOK];
  logic [TW-1:0]   wi, ro;
  logic [CW-1:0]   cnt;
  logic            retire;

  function automatic logic [TW-1:0] step(input logic [TW-1:0] p);
    return (p == TW'(NTOK - 1)) ? '0 : p + TW'(1);
  endfunction

  assign tok_ok    = (cnt < CW'(NTOK));
  assign alloc_tok = wi;
  assign out_valid = filled[ro];
  assign out_data  = slot[ro];
  assign retire    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (put) slot[put_tok] <= put_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled <= '0;
      wi     <= '0;
      ro     <= '0;
      cnt    <= '0;
    end else begin
      if (retire) filled[ro] <= 1'b0;
      if (put)    filled[put_tok] <= 1'b1;
      if (alloc)  wi <= step(wi);
      if (retire) ro <= step(ro);
      cnt <= cnt + CW'(alloc) - CW'(retire);
    end
  end

  p_alloc_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> tok_ok);
  p_put_free_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    put |-> !filled[put_tok]);
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/lpm_step.sv
module lpm_step
  import lpm_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [LVL_W-1:0]   lvl,
  input  logic [REM_W-1:0]   rem,
  output logic               done,
  output logic [AW-1:0]      nxt_addr,
  output logic [LVL_W-1:0]   nxt_lvl,
  output logic [REM_W-1:0]   nxt_rem
);
  // the deepest level is final whatever its flag says
  assign done     = entry[LEAF_BIT] || (lvl == LVL_LAST);
  assign nxt_addr = entry[AW-1:0] + AW'(rem[REM_W-1 -: 8]);
  assign nxt_lvl  = lvl + LVL_W'(1);
  assign nxt_rem  = {rem[REM_W-9:0], 8'h00};
endmodule

// File: rtl/lpm_engine.sv
module lpm_engine
  import lpm_pkg::*;
#(
  parameter int AW         = 20,
  parameter int FIFO_DEPTH = 4,
  parameter int NTOK       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [31:0]        req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [RES_W-1:0]   rsp_result,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [AW-1:0]      mem_req_addr,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [ENTRY_W-1:0] mem_rsp_data
);
  localparam int TW = (NTOK > 1) ? $clog2(NTOK) : 1;
  localparam int FW = TW + LVL_W + REM_W;

  logic [FW-1:0]    fifo_din, fifo_dout;
  logic             fifo_empty, fifo_space, fifo_push, fifo_pop;
  logic [TW-1:0]    hd_tok, new_tok;
  logic [LVL_W-1:0] hd_lvl, nxt_lvl;
  logic [REM_W-1:0] hd_rem, nxt_rem;
  logic [AW-1:0]    nxt_addr;
  logic             done, tok_ok;
  logic             recirc_want, recirc_fire, exit_fire, entry_want, enter_fire;

  assign {hd_tok, hd_lvl, hd_rem} = fifo_dout;

  lpm_step #(.AW(AW)) u_step (
    .entry(mem_rsp_data), .lvl(hd_lvl), .rem(hd_rem),
    .done(done), .nxt_addr(nxt_addr), .nxt_lvl(nxt_lvl), .nxt_rem(nxt_rem)
  );

  // arbitration: recirculation owns the RAM port when it needs it
  assign recirc_want = mem_rsp_valid && !done;
  assign recirc_fire = recirc_want && mem_req_ready;
  assign exit_fire   = mem_rsp_valid && done;
  assign entry_want  = req_valid && tok_ok && fifo_space && !recirc_want;
  assign enter_fire  = entry_want && mem_req_ready;

  assign req_ready     = enter_fire;
  assign mem_req_valid = recirc_want || entry_want;
  assign mem_req_addr  = recirc_want ? nxt_addr : AW'(req_addr[31:16]);
  assign mem_rsp_ready = exit_fire || recirc_fire;

  assign fifo_pop  = exit_fire || recirc_fire;
  assign fifo_push = enter_fire || recirc_fire;
  assign fifo_din  = recirc_fire ? {hd_tok, nxt_lvl, nxt_rem}
                                 : {new_tok, LVL_FIRST, req_addr[15:0]};

  lpm_loop_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .din(fifo_din),
    .pop(fifo_pop), .dout(fifo_dout), .empty(fifo_empty), .space(fifo_space)
  );

  lpm_cbuf #(.NTOK(NTOK), .RW(RES_W)) u_cbuf (
    .clk(clk), .rst_n(rst_n), .alloc(enter_fire), .tok_ok(tok_ok),
    .alloc_tok(new_tok), .put(exit_fire), .put_tok(hd_tok),
    .put_data(mem_rsp_data[RES_W-1:0]), .out_valid(rsp_valid),
    .out_ready(rsp_ready), .out_data(rsp_result)
  );

  p_entry_first_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |->
      (mem_req_valid && mem_req_ready && mem_req_addr == AW'(req_addr[31:16])));
  p_recirc_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && !mem_rsp_data[LEAF_BIT] && hd_lvl != LVL_LAST) |-> !req_ready);
  p_rsp_has_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !fifo_empty);
  p_exit_frees_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && mem_rsp_data[LEAF_BIT]) |-> mem_rsp_ready);
endmodule

// File: tb/test_lpm_engine.sv
`timescale 1ns/1ps
module test_lpm_engine;
  localparam int AW = 20, DEPTH = 4, NTOK = 8, LAT = 4;
  localparam int unsigned L2B = 65536, L3B = 67584;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, rsp_valid, rsp_ready = 0;
  logic [31:0] req_addr = '0;
  logic [30:0] rsp_result;
  logic mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0, mem_rsp_ready;
  logic [AW-1:0] mem_req_addr;
  logic [31:0] mem_rsp_data = '0;

  always #4 clk = ~clk;

  lpm_engine #(.AW(AW), .FIFO_DEPTH(DEPTH), .NTOK(NTOK)) i_lpm_engine (.*);

  int tests = 0, fails = 0, cyc = 0, acc_cnt = 0, last_acc_cyc = 0;
  int mr_mode = 0, rr_mode = 0;
  bit acc_now = 0, hold_prev = 0;
  logic [30:0] hold_val;
  logic [31:0] tab [int unsigned];
  logic [30:0] exp_q[$];
  int unsigned qa[$];
  int qd[$], ql[$];
  logic [31:0] qip[$];

  function automatic logic [31:0] tbl(input int unsigned a);
    if (tab.exists(a)) return tab[a];
    return {1'b1, 31'(a * 13 + 7)};
  endfunction

  function automatic logic [30:0] ref_lpm(input logic [31:0] ip);
    logic [31:0] e;
    e = tbl(int'(ip[31:16]));
    if (e[31]) return e[30:0];
    e = tbl((int'(e[AW-1:0]) + int'(ip[15:8])) & ((1 << AW) - 1));
    if (e[31]) return e[30:0];
    e = tbl((int'(e[AW-1:0]) + int'(ip[7:0])) & ((1 << AW) - 1));
    return e[30:0];
  endfunction

  function automatic logic [31:0] rand_ip();
    return {16'h0A00 + 16'($urandom % 8), 8'($urandom % 16), 8'($urandom % 8)};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // RAM model and port monitor
  always begin
    @(negedge clk);
    acc_now = 0;
    cyc++;
    mem_req_ready = (mr_mode == 0) ? 1'b1 : ($urandom % 4 != 0);
    rsp_ready = (rr_mode == 0) ? 1'b1 : (rr_mode == 1) ? ($urandom % 3 != 0) : 1'b0;
    if (qa.size() > 0 && qd[0] <= cyc) begin
      mem_rsp_valid = 1; mem_rsp_data = tbl(qa[0]);
    end else begin
      mem_rsp_valid = 0; mem_rsp_data = '0;
    end
    #2;
    if (rst_n) begin
      bit fin;
      int unsigned nxt;
      fin = 0; nxt = 0;
      if (hold_prev)  // R8
        chk(rsp_valid && rsp_result == hold_val, "R8 result held", rsp_result, hold_val);
      hold_prev = rsp_valid && !rsp_ready;
      hold_val  = rsp_result;
      if (req_valid && req_ready) begin
        chk(mem_req_valid && mem_req_ready && mem_req_addr == AW'(req_addr[31:16]),
            "R1 first-level address", mem_req_addr, req_addr[31:16]);
        exp_q.push_back(ref_lpm(req_addr));
        acc_now = 1; acc_cnt++; last_acc_cyc = cyc;
      end
      if (mem_rsp_valid) begin
        fin = mem_rsp_data[31] || ql[0] == 2;
        nxt = (int'(mem_rsp_data[AW-1:0]) +
               int'(ql[0] == 0 ? qip[0][15:8] : qip[0][7:0])) & ((1 << AW) - 1);
        chk(mem_rsp_ready == (fin || mem_req_ready), "R10 response consume",
            mem_rsp_ready, fin || mem_req_ready);
        if (!fin) begin
          chk(!req_ready, "R4 recirculation priority", req_ready, 0);
          if (mem_req_ready)
            chk(mem_req_valid && mem_req_addr == AW'(nxt), "R2 next-level address",
                mem_req_addr, nxt);
        end
      end
      if (mem_req_valid && mem_req_ready) begin
        qa.push_back(int'(mem_req_addr));
        qd.push_back(cyc + LAT);
        if (mem_rsp_valid && !fin) begin
          ql.push_back(ql[0] + 1); qip.push_back(qip[0]);
        end else begin
          ql.push_back(0); qip.push_back(req_addr);
        end
      end
      if (mem_rsp_valid && mem_rsp_ready) begin
        void'(qa.pop_front()); void'(qd.pop_front());
        void'(ql.pop_front()); void'(qip.pop_front());
      end
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) chk(0, "R6 unexpected result", rsp_result, 0);
        else begin
          logic [30:0] ev;
          ev = exp_q.pop_front();
          chk(rsp_result == ev, "R3/R6 result in order", rsp_result, ev);
        end
      end
    end
  end

  task automatic send(input logic [31:0] ip);
    @(negedge clk);
    req_valid = 1; req_addr = ip;
    do @(posedge clk); while (!acc_now);
  endtask

  task automatic idle_drain();
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);
  endtask

  initial begin
    #(8 * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c0, a0;
    void'($urandom(32'h5EED));
    tab[32'h0A00] = {1'b1, 31'h00AA0000};
    tab[32'h0A01] = {1'b1, 31'h00BB0001};
    for (int k = 2; k < 6; k++) begin
      tab[32'h0A00 + k] = {1'b0, 31'(L2B + k * 256)};
      for (int j = 0; j < 256; j += 4)
        tab[L2B + k * 256 + j] = {1'b0, 31'(L3B + (k * 64 + j / 4) * 256)};
    end
    tab[L3B + 128 * 256 + 5] = {1'b0, 31'h1234};  // depth-3 entry without leaf flag

    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #3;
    chk(!rsp_valid, "R9 reset rsp_valid", rsp_valid, 0);
    chk(!mem_req_valid, "R9 reset mem_req_valid", mem_req_valid, 0);
    chk(!req_ready, "R9 reset req_ready", req_ready, 0);

    // directed depths: R3
    send(32'h0A00_1234);          // first-level leaf
    send(32'h0A03_0100);          // second-level leaf
    send(32'h0A02_0005);          // third level, flag clear, still final
    send(32'h0A04_0403);          // third-level default leaf
    send(32'h0A07_0000);          // default first-level leaf
    chk(ref_lpm(32'h0A02_0005) == 31'h1234, "R3 depth-3 terminal value",
        ref_lpm(32'h0A02_0005), 31'h1234);
    idle_drain();

    // R5: leaf-only stream, one per cycle
    send(32'h0A00_0000);
    c0 = last_acc_cyc;
    for (int i = 1; i < 40; i++) send({16'h0A00 + 16'(i % 2), 16'(i)});
    chk(last_acc_cyc - c0 == 39, "R5 back-to-back admission", last_acc_cyc - c0, 39);
    idle_drain();

    // R7: token limit with consumer stalled
    rr_mode = 2;
    @(negedge clk);
    a0 = acc_cnt;
    req_valid = 1; req_addr = 32'h0A01_0000;
    repeat (40) @(negedge clk);
    #3;
    chk(acc_cnt - a0 == NTOK, "R7 in-flight limit", acc_cnt - a0, NTOK);
    chk(!req_ready, "R7 no token no admission", req_ready, 0);
    @(negedge clk);
    req_valid = 0; rr_mode = 0;
    idle_drain();

    // random traffic with stalls on both sides
    mr_mode = 1; rr_mode = 1;
    for (int i = 0; i < 400; i++) send(rand_ip());
    idle_drain();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule